// File: doc/BRIEF.md
# Self-Timed Byte-Wide Nonvolatile Memory Model

This block is a synthesizable stand-in for a parallel, byte-wide nonvolatile memory. It has a static-RAM-style control set: active-low chip select, output enable and write strobe, a 13-bit address and a split 8-bit data bus. Every control input is sampled on the system clock. A byte write does not complete while the strobe is held. After the strobe pulse ends, an internal countdown runs for a fixed number of cycles. During that time the busy line is driven low, and every read returns a polling word.

The analog conditions of a real part reach the block as digital flags. A supply-low flag blocks writes, and a lockout countdown keeps them blocked for a while after the flag drops and after reset. A high-voltage flag on the output-enable pin, held with the strobes low for long enough, sets the whole main array to ones. A sideband identification flag maps the top 32 addresses to a separate 32-byte store. Storage is a register array whose depth is a parameter. Address bits above that depth are not decoded, so the array aliases.

Top module: `selftimed_nvm`

## Requirements
- R1: `dout_en` is 1 in the cycle after a clock edge that samples `ce_n`=0, `oe_n`=0 and `we_n`=1, and is 0 after any other sample. `dout` is 0 whenever `dout_en` is 0.
- R2: The write address is captured at the first edge where `ce_n`, `we_n` (both low) and `oe_n` (high) together form a strobe. The address is taken from whichever of `ce_n` and `we_n` went low last. The stored byte is the `din` sampled at the last edge before the strobe ends.
- R3: A write may end on `we_n` rising or on `ce_n` rising. Once the write cycle is over, a read of that address returns the written byte on all 8 bits.
- R4: While a write cycle runs, every read returns the polling word. In that word bit 7 is the inverse of bit 7 of the byte being written, and bits 6..0 are 0.
- R5: `busy_n` is low for exactly WRITE_CYC cycles. It goes low on the edge that samples the end of the strobe, and it is 1 out of reset.
- R6: No write starts while `oe_n` is sampled low.
- R7: No write starts or launches while `supply_low` is 1. No write starts for POR_CYC cycles after `supply_low` drops, and none for POR_CYC cycles after reset.
- R8: With `id_sel`=1, addresses 0x1FE0..0x1FFF read and write a separate 32-byte store indexed by address bits 4..0. With `id_sel`=0, the same addresses reach the main array.
- R9: When `ce_n`=0, `we_n`=0 and `hv_oe`=1 are sampled for CLEAR_CYC consecutive edges, every main-array byte becomes 0xFF. The identification store does not change. A shorter hold clears nothing.
- R10: A write strobe that arrives while a write cycle runs is ignored. It changes no byte and does not extend busy.
- R11: Only the low MEM_AW address bits index the main array. Addresses that differ only above those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Drive enable for the data bus |
| busy_n | output | 1 | Ready/busy, low while a write cycle runs |
| supply_low | input | 1 | Supply-below-threshold flag |
| hv_oe | input | 1 | High-voltage-on-output-enable flag |
| id_sel | input | 1 | Identification-store select flag |

## Verification
A wrong countdown shows up on `busy_n` on the very clock where its length differs from WRITE_CYC. It also shows up in the first read that returns a polling word where true data is due, or true data where a polling word is due. A stale captured address or byte stays hidden until that location is read after the cycle ends, so every write is followed by a readback. Lockout or clear state that is off by a cycle is exposed by strobes and clear pulses placed right at the boundary, and it shows at `busy_n` one cycle after the strobe ends.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_ARRAY = 2'd1,
      SRC_IDENT = 2'd2,
      SRC_POLL  = 2'd3
   } rd_src_e;
endpackage

// File: rtl/nvm_strobe.sv
module nvm_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic we_n,
   input  logic oe_n,
   input  logic hv_oe,
   output logic act,
   output logic begin_p,
   output logic end_p
);
   logic act_q;

   assign act     = ~ce_n & ~we_n & oe_n & ~hv_oe;
   assign begin_p = act & ~act_q;
   assign end_p   = ~act & act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act;
   end
endmodule

// File: rtl/nvm_countdown.sv
module nvm_countdown #(
   parameter int LOAD        = 20,
   parameter bit LOAD_ON_RST = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic active
);
   localparam int CW = $clog2(LOAD + 1);
   localparam logic [CW-1:0] LOADV = CW'(LOAD);

   generate
      if (LOAD < 1) begin : g_bad_load
         $error("nvm_countdown: LOAD must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= LOAD_ON_RST ? LOADV : '0;
      else if (load)           cnt_q <= LOADV;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOADV); // R5
   AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> active); // R7
endmodule

// File: rtl/selftimed_nvm.sv
module selftimed_nvm #(
   parameter int ADDR_W    = 13,
   parameter int DATA_W    = 8,
   parameter int MEM_AW    = 10,
   parameter int ID_AW     = 5,
   parameter bit ID_EN     = 1'b1,
   parameter int WRITE_CYC = 20,
   parameter int POR_CYC   = 12,
   parameter int CLEAR_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              busy_n,
   input  logic              supply_low,
   input  logic              hv_oe,
   input  logic              id_sel
);
   import nvm_pkg::*;

   localparam int MEM_DEPTH = 1 << MEM_AW;
   localparam int ID_DEPTH  = 1 << ID_AW;
   localparam int CCW       = $clog2(CLEAR_CYC + 1);
   localparam logic [CCW-1:0] CLR_LAST = CCW'(CLEAR_CYC - 1);
   localparam logic [CCW-1:0] CLR_DONE = CCW'(CLEAR_CYC);

   generate
      if (DATA_W < 2)       begin : g_bad_dw  $error("DATA_W must be at least 2");     end
      if (MEM_AW > ADDR_W)  begin : g_bad_maw $error("MEM_AW exceeds ADDR_W");        end
      if (ID_AW >= ADDR_W || ID_AW > MEM_AW)
                            begin : g_bad_iaw $error("ID_AW out of range");           end
      if (CLEAR_CYC < 2)    begin : g_bad_clr $error("CLEAR_CYC must be at least 2"); end
   endgenerate

   // strobe decode
   logic wr_act, wr_begin, wr_end;
   nvm_strobe u_strobe (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .hv_oe(hv_oe), .act(wr_act), .begin_p(wr_begin), .end_p(wr_end)
   );

   // power-on / supply lockout
   logic por_run, locked;
   nvm_countdown #(.LOAD(POR_CYC), .LOAD_ON_RST(1'b1)) u_lockout (
      .clk(clk), .rst_n(rst_n), .load(supply_low), .active(por_run)
   );
   assign locked = supply_low | por_run;

   // write cycle timer
   logic busy, launch;
   nvm_countdown #(.LOAD(WRITE_CYC), .LOAD_ON_RST(1'b0)) u_wtimer (
      .clk(clk), .rst_n(rst_n), .load(launch), .active(busy)
   );

   // capture of address and data
   logic              pend_q, cap_id_q, start_ok;
   logic [MEM_AW-1:0] cap_addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              id_hit;

   assign id_hit   = ID_EN & id_sel & (&addr[ADDR_W-1:ID_AW]);
   assign start_ok = wr_begin & ~busy & ~locked;
   assign launch   = wr_end & pend_q & ~locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         cap_id_q   <= 1'b0;
         cap_addr_q <= '0;
         wdata_q    <= '0;
      end else begin
         if (start_ok) begin
            pend_q     <= 1'b1;
            cap_id_q   <= id_hit;
            cap_addr_q <= addr[MEM_AW-1:0];
         end else if (wr_end) begin
            pend_q     <= 1'b0;
         end
         if (wr_act & (start_ok | pend_q)) wdata_q <= din;
      end
   end

   // whole-array clear
   logic           clr_cond, do_clear;
   logic [CCW-1:0] clr_cnt_q;
   assign clr_cond = ~ce_n & ~we_n & hv_oe & ~busy & ~locked;
   assign do_clear = clr_cond & (clr_cnt_q == CLR_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     clr_cnt_q <= '0;
      else if (!clr_cond)             clr_cnt_q <= '0;
      else if (clr_cnt_q != CLR_DONE) clr_cnt_q <= clr_cnt_q + 1'b1;
   end

   // main array: the byte is erased and reprogrammed as one update at launch,
   // then hidden behind the polling word until the timer expires
   logic [DATA_W-1:0] mem_q [MEM_DEPTH];
   always_ff @(posedge clk) begin
      if (do_clear) begin
         for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '1;
      end else if (launch && !cap_id_q) begin
         mem_q[cap_addr_q] <= wdata_q;
      end
   end

   // identification store
   logic [DATA_W-1:0] id_rd;
   generate
      if (ID_EN) begin : g_ident
         logic [DATA_W-1:0] id_q [ID_DEPTH];
         always_ff @(posedge clk) begin
            if (launch && cap_id_q) id_q[cap_addr_q[ID_AW-1:0]] <= wdata_q;
         end
         assign id_rd = id_q[addr[ID_AW-1:0]];
      end else begin : g_no_ident
         assign id_rd = '0;
      end
   endgenerate

   // read path
   logic    rd_now;
   rd_src_e src;
   logic [DATA_W-1:0] poll_word, dout_q;
   logic    en_q;

   assign rd_now    = ~ce_n & ~oe_n & we_n;
   assign poll_word = {~wdata_q[DATA_W-1], {(DATA_W-1){1'b0}}};

   always_comb begin
      if (!rd_now)     src = SRC_NONE;
      else if (busy)   src = SRC_POLL;
      else if (id_hit) src = SRC_IDENT;
      else             src = SRC_ARRAY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         dout_q <= '0;
      end else begin
         en_q <= rd_now;
         unique case (src)
            SRC_POLL:  dout_q <= poll_word;
            SRC_IDENT: dout_q <= id_rd;
            SRC_ARRAY: dout_q <= mem_q[addr[MEM_AW-1:0]];
            default:   dout_q <= '0;
         endcase
      end
   end

   assign dout    = dout_q;
   assign dout_en = en_q;
   assign busy_n  = ~busy;

   AST_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n | oe_n) |=> (!dout_en && dout == '0)); // R1
   AST_POLL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_now) |=> (dout[DATA_W-1] == ~wdata_q[DATA_W-1] && dout[DATA_W-2:0] == '0)); // R4
   AST_BUSY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !busy_n); // R5
   AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n && !pend_q) |=> !pend_q); // R6
   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> !$rose(busy)); // R7
   AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !pend_q); // R10
endmodule

// File: tb/selftimed_nvm_tb_top.sv
`timescale 1ns/1ps
module selftimed_nvm_tb_top;
   localparam int WCYC = 20;
   localparam int PCYC = 12;
   localparam int CCYC = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [12:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic dout_en, busy_n;
   logic supply_low = 1'b0, hv_oe = 1'b0, id_sel = 1'b0;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   selftimed_nvm #(.WRITE_CYC(WCYC), .POR_CYC(PCYC), .CLEAR_CYC(CCYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy_n(busy_n),
      .supply_low(supply_low), .hv_oe(hv_oe), .id_sel(id_sel)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // behavioural reference model
   logic [7:0] m_mem [int];
   logic [7:0] m_id  [int];
   bit   m_prev, m_pend, m_busy, m_cid, m_en;
   int   m_wcnt, m_lcnt, m_ccnt, m_caddr;
   logic [7:0] m_data, m_dout;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_prev = 0; m_pend = 0; m_busy = 0; m_wcnt = 0; m_lcnt = PCYC;
         m_ccnt = 0; m_en = 0; m_dout = 8'h00;
      end else begin
         bit act, lck, rd, b_old, hit;
         logic [7:0] nd;
         act   = !ce_n && !we_n && oe_n && !hv_oe;
         lck   = supply_low || (m_lcnt != 0);
         rd    = !ce_n && !oe_n && we_n;
         b_old = m_busy;
         hit   = id_sel && (addr >= 13'h1FE0);
         nd = 8'h00;
         if (rd) begin
            if (m_busy) nd = {~m_data[7], 7'h00};
            else if (hit) nd = m_id.exists(int'(addr[4:0])) ? m_id[int'(addr[4:0])] : 8'hxx;
            else nd = m_mem.exists(int'(addr[9:0])) ? m_mem[int'(addr[9:0])] : 8'hxx;
         end
         if (!(!ce_n && !we_n && hv_oe && !m_busy && !lck)) m_ccnt = 0;
         else if (m_ccnt < CCYC - 1) m_ccnt++;
         else if (m_ccnt == CCYC - 1) begin
            for (int i = 0; i < 1024; i++) m_mem[i] = 8'hFF;
            m_ccnt = CCYC;
         end
         if (m_busy) begin
            m_wcnt--;
            if (m_wcnt == 0) begin
               m_busy = 0;
               if (m_cid) m_id[m_caddr % 32] = m_data;
               else       m_mem[m_caddr] = m_data;
            end
         end
         if (act && !m_prev && !b_old && !lck) begin
            m_pend = 1; m_caddr = int'(addr[9:0]); m_cid = hit;
         end
         if (act && m_pend) m_data = din;
         if (!act && m_prev && m_pend) begin
            m_pend = 0;
            if (!lck) begin m_busy = 1; m_wcnt = WCYC; end
         end
         m_prev = act;
         if (supply_low) m_lcnt = PCYC; else if (m_lcnt != 0) m_lcnt--;
         m_en = rd; m_dout = nd;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 cycle busy_n", busy_n, !m_busy);
         chk("R1 cycle dout_en", dout_en, m_en);
         if (!$isunknown(m_dout)) chk("R3 cycle dout", dout, m_dout);
      end
   end

   task automatic idle();
      ce_n = 1; oe_n = 1; we_n = 1; hv_oe = 0;
   endtask

   task automatic wr_we(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; din = d; ce_n = 0; oe_n = 1; we_n = 0;
      repeat (3) @(negedge clk);
      we_n = 1;
      @(negedge clk); ce_n = 1;
   endtask

   task automatic wr_ce(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; din = d; we_n = 0; oe_n = 1; ce_n = 1;
      @(negedge clk); ce_n = 0;
      repeat (3) @(negedge clk);
      ce_n = 1;
      @(negedge clk); we_n = 1;
   endtask

   task automatic rd(input logic [12:0] a, input logic ids, output logic [7:0] v);
      @(negedge clk); addr = a; id_sel = ids; ce_n = 0; oe_n = 0; we_n = 1;
      @(negedge clk); v = dout;
      idle(); id_sel = 0;
   endtask

   task automatic wait_ready();
      while (!busy_n) @(negedge clk);
   endtask

   task automatic clear_pulse(input int cyc);
      @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; hv_oe = 1;
      repeat (cyc) @(negedge clk);
      idle();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog (all requirements) got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] v;
      int lowc;
      repeat (3) @(negedge clk);
      chk("R1 reset dout_en", dout_en, 1'b0);
      chk("R5 reset busy_n", busy_n, 1'b1);
      rst_n = 1;
      // R7: lockout right after reset
      wr_we(13'h0005, 8'h12);
      chk("R7 write in reset lockout", busy_n, 1'b1);
      repeat (PCYC + 4) @(negedge clk);
      // R9: full clear
      clear_pulse(CCYC + 2);
      @(negedge clk);
      rd(13'h0005, 0, v); chk("R9 clear sets 0xFF", v, 8'hFF);
      rd(13'h03FF, 0, v); chk("R9 clear top byte", v, 8'hFF);
      // R3/R4/R5
      wr_we(13'h0012, 8'hA5);
      chk("R5 busy after strobe end", busy_n, 1'b0);
      rd(13'h0012, 0, v); chk("R4 poll word bit7=1", v, 8'h00);
      rd(13'h0100, 0, v); chk("R4 poll any address", v, 8'h00);
      // R10: strobe during busy ignored
      wr_we(13'h0013, 8'h11);
      wait_ready();
      rd(13'h0012, 0, v); chk("R3 true data after cycle", v, 8'hA5);
      rd(13'h0013, 0, v); chk("R10 ignored write left byte", v, 8'hFF);
      // R11 aliasing
      rd(13'h0412, 0, v); chk("R11 alias above MEM_AW", v, 8'hA5);
      // R5 busy length
      wr_we(13'h0030, 8'h35);
      lowc = 0;
      while (!busy_n) begin lowc++; @(negedge clk); end
      chk("R5 busy length", lowc, WCYC);
      rd(13'h0030, 0, v); chk("R3 written 0x35", v, 8'h35);
      // R4 poll with bit7=0
      wr_we(13'h0031, 8'h7E);
      rd(13'h0031, 0, v); chk("R4 poll word bit7=0", v, 8'h80);
      wait_ready();
      // R3 chip-enable controlled write
      wr_ce(13'h0020, 8'h3C);
      chk("R3 ce strobe starts cycle", busy_n, 1'b0);
      wait_ready();
      rd(13'h0020, 0, v); chk("R3 ce strobe data", v, 8'h3C);
      // R2 address at start, data at end
      @(negedge clk); addr = 13'h0040; din = 8'h01; ce_n = 0; oe_n = 1; we_n = 0;
      @(negedge clk); addr = 13'h0041; din = 8'h02;
      @(negedge clk); din = 8'h5A;
      @(negedge clk); we_n = 1;
      @(negedge clk); ce_n = 1;
      wait_ready();
      rd(13'h0040, 0, v); chk("R2 data from last strobe cycle", v, 8'h5A);
      rd(13'h0041, 0, v); chk("R2 address from strobe start", v, 8'hFF);
      // R6 oe low blocks
      @(negedge clk); addr = 13'h0050; din = 8'h44; ce_n = 0; oe_n = 0; we_n = 0;
      repeat (3) @(negedge clk);
      we_n = 1;
      @(negedge clk); idle();
      chk("R6 oe low no busy", busy_n, 1'b1);
      rd(13'h0050, 0, v); chk("R6 byte unchanged", v, 8'hFF);
      // R7 supply low
      supply_low = 1;
      wr_we(13'h0060, 8'h66);
      chk("R7 supply low blocks", busy_n, 1'b1);
      supply_low = 0;
      wr_we(13'h0060, 8'h67);
      chk("R7 lockout after supply drop", busy_n, 1'b1);
      repeat (PCYC + 2) @(negedge clk);
      wr_we(13'h0060, 8'h68);
      chk("R7 write after lockout", busy_n, 1'b0);
      wait_ready();
      rd(13'h0060, 0, v); chk("R7 only late write stored", v, 8'h68);
      // R8 identification store
      @(negedge clk); id_sel = 1;
      wr_we(13'h1FE3, 8'h77);
      wait_ready();
      @(negedge clk); id_sel = 0;
      rd(13'h1FE3, 1, v); chk("R8 id store read", v, 8'h77);
      rd(13'h1FE3, 0, v); chk("R8 main array at same address", v, 8'hFF);
      wr_we(13'h1FE3, 8'h99);
      wait_ready();
      rd(13'h1FE3, 1, v); chk("R8 id store untouched by main write", v, 8'h77);
      rd(13'h03E3, 0, v); chk("R8 main write lands in array", v, 8'h99);
      // R9 short pulse does nothing, full pulse spares id store
      clear_pulse(CCYC - 2);
      @(negedge clk);
      rd(13'h0012, 0, v); chk("R9 short pulse no clear", v, 8'hA5);
      clear_pulse(CCYC + 1);
      @(negedge clk);
      rd(13'h0012, 0, v); chk("R9 full pulse clears", v, 8'hFF);
      rd(13'h1FE3, 1, v); chk("R9 id store kept", v, 8'h77);
      // R1 tristate combinations
      @(negedge clk); ce_n = 1; oe_n = 0; we_n = 1;
      @(negedge clk); chk("R1 ce high tristate", dout_en, 1'b0);
      ce_n = 0; oe_n = 1;
      @(negedge clk); chk("R1 oe high tristate", dout_en, 1'b0);
      chk("R1 dout zero when off", dout, 8'h00);
      idle();
      repeat (3) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule